// File: doc/BRIEF.md
# Narrow-Width Flag Evaluation Unit

This unit sits in an integer pipeline and recognises one 32-bit instruction form with two width variants. Each variant reads one source register and recomputes three condition flags from the low 8 or the low 16 bits of that register. The flags are negative, zero and a "sign-extension mismatch" flag. The carry flag is carried through untouched. The unit holds the resulting four-bit NZCV state itself.

Each cycle, the pipeline presents an instruction word with a valid strobe. The unit drives the source register index back out in the same cycle, combinationally, and samples the returned read data in that cycle. On the following clock edge the unit does three things:
- it updates the flags,
- it raises a one-cycle `handled` pulse, or
- it raises a one-cycle `undef` pulse if the form is recognised but not permitted.

Words that are not this form are left alone, so another decoder can claim them. The path is a single fixed cycle. Both width variants are always computed in parallel, so timing never depends on the operand or the current flags.

Top module: `flagev_unit`

## Requirements
- R1: After synchronous reset, `flags_q` is 4'b0000 and both `handled` and `undef` are 0.
- R2: A word is recognised when `(insn_word & 32'h7FFF_BC1F) == 32'h3A00_080D`. Bit 31 is the form-select bit, bit 14 selects the width and bits 9:5 are the register index. A recognised word with `insn_valid`=1, `feat_en`=1 and bit 31 = 0 causes `handled` to be 1 for exactly the next cycle and updates `flags_q` at that same edge.
- R3: Flag layout is N=`flags_q[3]`, Z=`flags_q[2]`, C=`flags_q[1]`, V=`flags_q[0]`. With bit 14 = 0 (8-bit form), the new flags are N=data[7], Z=(data[7:0]==0) and V=data[8]^data[7].
- R4: With bit 14 = 1 (16-bit form), the new flags are N=data[15], Z=(data[15:0]==0) and V=data[16]^data[15].
- R5: The C flag (`flags_q[1]`) never changes outside reset.
- R6: A recognised valid word with `feat_en`=0 or with bit 31 = 1 causes `undef` to be 1 for exactly the next cycle. In that case `handled` stays 0 and `flags_q` is unchanged.
- R7: A valid word that is not recognised raises neither pulse and leaves `flags_q` unchanged.
- R8: `rf_idx` equals `insn_word[9:5]` in the same cycle, with no register in between.
- R9: When `insn_valid` is 0, no pulse is raised and `flags_q` is unchanged, whatever the word.
- R10: The result always appears exactly one cycle after the valid word, for every operand value and width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | Instruction word is valid this cycle |
| insn_word | input | 32 | Instruction word |
| feat_en | input | 1 | Feature enable; 0 makes the form undefined |
| rf_idx | output | 5 | Source register index to the register file |
| rf_data | input | 32 | Register read data for `rf_idx`, same cycle |
| flags_q | output | 4 | NZCV flag state {N,Z,C,V} |
| handled | output | 1 | One-cycle pulse: instruction executed |
| undef | output | 1 | One-cycle pulse: instruction undefined |

## Verification
The hardest outcomes to bring about are the V flag and the zero flag taken from the selected width alone. They need operands whose bits just above the width boundary disagree with the sign bit. They also need operands whose low part is zero while higher bits are set, such as 0x100 for the 8-bit form and 0x10000 for the 16-bit form. The bench drives such values through a small register-file model indexed by the unit's own `rf_idx`, so a wrong index also shows up as wrong flags. Undefined and foreign words are issued between evaluations that set the flags to non-zero values, so any disturbance of the flags is visible.

// File: rtl/flagev_pkg.sv
package flagev_pkg;

    localparam int XLEN     = 32;
    localparam int RIDX_W   = 5;
    localparam int FORM_BIT = 31;
    localparam int WSEL_BIT = 14;
    localparam int RIDX_LO  = 5;

    // Fixed bits of the recognised form (form-select, width and index excluded)
    localparam logic [XLEN-1:0] ENC_CARE = 32'h7FFF_BC1F;
    localparam logic [XLEN-1:0] ENC_VAL  = 32'h3A00_080D;

    // Operand widths evaluated in parallel
    localparam int NUM_W      = 2;
    localparam int NARROW_W0  = 8;
    localparam int NARROW_W1  = 16;

    typedef enum logic {
        OPW_BYTE = 1'b0,
        OPW_HALF = 1'b1
    } opw_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
    } nzv_t;

    typedef struct packed {
        logic              hit;
        logic              illegal;
        opw_e              width;
        logic [RIDX_W-1:0] src;
    } dec_t;

    function automatic int width_of(input int sel);
        return (sel == 0) ? NARROW_W0 : NARROW_W1;
    endfunction

endpackage

// File: rtl/flagev_decode.sv
module flagev_decode
    import flagev_pkg::*;
(
    input  logic            valid,
    input  logic [XLEN-1:0] word,
    input  logic            feat_en,
    output dec_t            dec
);
    logic pattern_ok;

    always_comb begin
        pattern_ok  = ((word & ENC_CARE) == ENC_VAL);
        dec.hit     = valid && pattern_ok;
        dec.illegal = !feat_en || word[FORM_BIT];
        dec.width   = opw_e'(word[WSEL_BIT]);
        dec.src     = word[RIDX_LO +: RIDX_W];
    end
endmodule

// File: rtl/flagev_eval.sv
module flagev_eval
    import flagev_pkg::*;
(
    input  logic [XLEN-1:0] data,
    input  opw_e            width,
    output nzv_t            nzv
);
    nzv_t cand [NUM_W];

    // Every width is evaluated each cycle; selection is a plain mux,
    // so the path length never depends on the data.
    for (genvar g = 0; g < NUM_W; g++) begin : g_width
        localparam int TOP = width_of(g) - 1;
        always_comb begin
            cand[g].n = data[TOP];
            cand[g].z = (data[TOP:0] == '0);
            cand[g].v = data[TOP+1] ^ data[TOP];
        end
    end

    always_comb begin
        nzv = (width == OPW_HALF) ? cand[1] : cand[0];
    end
endmodule

// File: rtl/flagev_state.sv
module flagev_state
    import flagev_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  dec_t  dec,
    input  nzv_t  nzv,
    output nzcv_t flags,
    output logic  handled,
    output logic  undef
);
    logic commit;

    always_comb commit = dec.hit && !dec.illegal;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags   <= '0;
            handled <= 1'b0;
            undef   <= 1'b0;
        end else begin
            handled <= commit;
            undef   <= dec.hit && dec.illegal;
            if (commit) begin
                flags.n <= nzv.n;
                flags.z <= nzv.z;
                flags.v <= nzv.v;
            end
        end
    end
endmodule

// File: rtl/flagev_unit.sv
module flagev_unit
    import flagev_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        insn_valid,
    input  logic [31:0] insn_word,
    input  logic        feat_en,
    output logic [4:0]  rf_idx,
    input  logic [31:0] rf_data,
    output logic [3:0]  flags_q,
    output logic        handled,
    output logic        undef
);
    dec_t  dec;
    nzv_t  nzv;
    nzcv_t flags;

    flagev_decode u_decode (
        .valid   (insn_valid),
        .word    (insn_word),
        .feat_en (feat_en),
        .dec     (dec)
    );

    flagev_eval u_eval (
        .data  (rf_data),
        .width (dec.width),
        .nzv   (nzv)
    );

    flagev_state u_state (
        .clk     (clk),
        .rst     (rst),
        .dec     (dec),
        .nzv     (nzv),
        .flags   (flags),
        .handled (handled),
        .undef   (undef)
    );

    assign rf_idx  = dec.src;
    assign flags_q = flags;
endmodule

// File: rtl/flagev_unit_chk.sv
module flagev_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        insn_valid,
    input logic [31:0] insn_word,
    input logic        feat_en,
    input logic [31:0] rf_data,
    input logic [3:0]  flags_q,
    input logic        handled,
    input logic        undef
);
    AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        !(handled && undef)); // R6

    AST_CARRY_HELD: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> flags_q[1] == $past(flags_q[1])); // R5

    AST_FLAGS_ONLY_ON_HANDLED: assert property (@(posedge clk) disable iff (rst)
        (flags_q != $past(flags_q)) |-> handled); // R7

    AST_HANDLED_CAUSE: assert property (@(posedge clk) disable iff (rst)
        handled |-> $past(insn_valid && feat_en && !insn_word[31])); // R2

    AST_UNDEF_CAUSE: assert property (@(posedge clk) disable iff (rst)
        undef |-> $past(insn_valid && (!feat_en || insn_word[31]))); // R6

    AST_NEG_FROM_SIGN: assert property (@(posedge clk) disable iff (rst)
        handled |-> flags_q[3] == ($past(insn_word[14]) ? $past(rf_data[15])
                                                        : $past(rf_data[7]))); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !insn_valid |=> !handled && !undef); // R9
endmodule

bind flagev_unit flagev_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .insn_valid (insn_valid),
    .insn_word  (insn_word),
    .feat_en    (feat_en),
    .rf_data    (rf_data),
    .flags_q    (flags_q),
    .handled    (handled),
    .undef      (undef)
);

// File: tb/flagev_unit_tb.sv
`timescale 1ns/1ps
module flagev_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        insn_valid = 1'b0;
    logic [31:0] insn_word = '0;
    logic        feat_en = 1'b1;
    logic [4:0]  rf_idx;
    logic [31:0] rf_data;
    logic [3:0]  flags_q;
    logic        handled;
    logic        undef;

    logic [31:0] regs [32];
    logic [3:0]  mflags = 4'b0000;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;
    assign rf_data = regs[rf_idx];

    flagev_unit u_dut (
        .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn_word(insn_word),
        .feat_en(feat_en), .rf_idx(rf_idx), .rf_data(rf_data),
        .flags_q(flags_q), .handled(handled), .undef(undef)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit sf, input bit sz, input logic [4:0] rn);
        return 32'h3A00_080D | ({31'd0, sf} << 31) | ({31'd0, sz} << 14) | ({27'd0, rn} << 5);
    endfunction

    function automatic logic [3:0] model(input logic [3:0] old, input bit sz, input logic [31:0] d);
        logic n, z, v;
        if (sz) begin
            n = d[15]; z = (d[15:0] == 16'h0); v = d[16] ^ d[15];
        end else begin
            n = d[7];  z = (d[7:0] == 8'h0);   v = d[8] ^ d[7];
        end
        return {n, z, old[1], v};
    endfunction

    // Issue one word for one cycle; check index, pulses, flags and pulse end.
    task automatic issue(input string req, input logic [31:0] w, input bit vld,
                         input bit fe, input logic [31:0] d, input bit exp_h, input bit exp_u);
        @(negedge clk);
        regs[w[9:5]] = d;
        insn_word  = w;
        insn_valid = vld;
        feat_en    = fe;
        #0.5;
        check({req, "/R8 idx"}, {27'd0, rf_idx}, {27'd0, w[9:5]});
        if (exp_h) mflags = model(mflags, w[14], d);
        @(posedge clk); #1;
        check({req, " handled"}, {31'd0, handled}, {31'd0, exp_h});
        check({req, " undef"}, {31'd0, undef}, {31'd0, exp_u});
        check({req, " flags"}, {28'd0, flags_q}, {28'd0, mflags});
        @(negedge clk);
        insn_valid = 1'b0;
        feat_en    = 1'b1;
        @(posedge clk); #1;
        check({req, "/R10 pulse ends"}, {30'd0, handled, undef}, 32'd0);
        check({req, "/R5 carry"}, {31'd0, flags_q[1]}, 32'd0);
    endtask

    task automatic t_reset();
        check("R1 flags", {28'd0, flags_q}, 32'd0);
        check("R1 pulses", {30'd0, handled, undef}, 32'd0);
    endtask

    task automatic t_byte();
        issue("R3 zero",     mk(0,0,5'd1),  1, 1, 32'h0000_0000, 1, 0);
        issue("R3 neg+v",    mk(0,0,5'd2),  1, 1, 32'h0000_0080, 1, 0);
        issue("R3 neg",      mk(0,0,5'd3),  1, 1, 32'h0000_0180, 1, 0);
        issue("R3 hi-only",  mk(0,0,5'd4),  1, 1, 32'hFFFF_FF00, 1, 0);
        issue("R3 v-only",   mk(0,0,5'd31), 1, 1, 32'h0000_0155, 1, 0);
    endtask

    task automatic t_half();
        issue("R4 neg+v",    mk(0,1,5'd6),  1, 1, 32'h0000_8000, 1, 0);
        issue("R4 hi-only",  mk(0,1,5'd7),  1, 1, 32'h0001_0000, 1, 0);
        issue("R4 neg",      mk(0,1,5'd8),  1, 1, 32'h0001_8000, 1, 0);
        issue("R4 pos",      mk(0,1,5'd0),  1, 1, 32'hABCD_1234, 1, 0);
        issue("R10 byte val", mk(0,1,5'd9), 1, 1, 32'h0000_0080, 1, 0);
    endtask

    task automatic t_undef();
        issue("R4 set", mk(0,1,5'd10), 1, 1, 32'h0000_8000, 1, 0);
        issue("R6 feat off", mk(0,0,5'd11), 1, 0, 32'h0000_0000, 0, 1);
        issue("R6 form bit", mk(1,1,5'd12), 1, 1, 32'h0000_0000, 0, 1);
    endtask

    task automatic t_foreign();
        issue("R7 bit30", mk(0,0,5'd13) | 32'h4000_0000, 1, 1, 32'h0, 0, 0);
        issue("R7 bit4",  mk(0,1,5'd14) | 32'h0000_0010, 1, 1, 32'h0, 0, 0);
        issue("R7 bit0",  mk(0,0,5'd15) & ~32'h1,         1, 1, 32'h0, 0, 0);
    endtask

    task automatic t_idle();
        issue("R9 idle", mk(0,0,5'd16), 0, 1, 32'h0, 0, 0);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) regs[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst = 1'b0;
        t_byte();
        t_half();
        t_undef();
        t_foreign();
        t_idle();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end
endmodule